// File: doc/BRIEF.md
# Identification String Responder on a Two-Wire Bus

This block is a receive-and-transmit slave on a standard-mode (up to 100 kHz) I2C bus. It holds a fixed 17-byte identification string that a host reads to learn that the attached adapter can carry HDMI traffic. SCL and SDA are sampled on a fast system clock. SDA is driven only through an open-drain enable, so the block never drives the line high.

A host may first write one offset byte to set the read pointer. Either after that write or straight away, the host issues a read and receives bytes from the pointer onwards. The pointer advances on each master ACK and stops at the last location. Two level inputs gate the responder. One enables it. The other is a power-up input: when it is low, the block is held idle and ignores the bus.

Top module: `i2c_id_responder`

## Requirements
- R1: After reset the block releases SDA (`sda_oe` = 0) and the read pointer is 0x00.
- R2: The block acknowledges (pulls SDA low during the ninth SCL high phase) only the 7-bit address 1000000, which is byte 0x80 for a write and 0x81 for a read. For any other address it gives no ACK and stays off the bus until the next START.
- R3: In a write, the first byte after the address is acknowledged and loaded into the pointer. Values above 0x10 are clamped to 0x10. Any further written bytes are acknowledged and then discarded.
- R4: In a read, the byte at the pointer is shifted out most significant bit first. Each bit is driven after SCL falls and is valid for the whole SCL high phase that follows.
- R5: A master ACK (SDA low on the ninth clock) advances the pointer and starts the next byte. A master NACK makes the block release SDA and stop sending, and the pointer stays on the byte just sent.
- R6: Locations 0x00 to 0x10 hold 44 50 2D 48 44 4D 49 20 41 44 41 50 54 4F 52 04 FF.
- R7: The pointer never goes above 0x10. Once it is at 0x10, each further ACK returns 0xFF again.
- R8: A read issued without an earlier offset write returns data from the current pointer, which is 0x00 after reset.
- R9: While `slave_en` is low the block does not acknowledge its address and keeps SDA released. The pointer is cleared, so the first read after re-enabling starts at 0x00.
- R10: While `pwr_up` is low the block ignores all bus activity and releases SDA. The pointer is cleared, so the first read after power-up starts at 0x00.
- R11: A START (SDA falling while SCL is high) at any point, including a repeated START, restarts address reception. A STOP (SDA rising while SCL is high) returns the block to idle.
- R12: `sda_oe` changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| slave_en | input | 1 | 1 lets the block answer; 0 disables it |
| pwr_up | input | 1 | 1 for normal operation; 0 holds the block idle |

## Verification
Each bus line passes through two synchronizer flops, three filter-history flops and a filtered-level flop. The edge detector and the state register add two more stages, so any SDA change the block makes appears about 8 system clocks after the SCL edge that caused it. The bench moves one bus wire at a time, once every 20 system clocks, and it samples SDA 20 clocks after raising SCL. Every acknowledge and data bit is therefore read long after the block has settled. Data bits are sampled a second time just before SCL falls, which confirms they stay stable through the high phase. Effects of the enable and power inputs are checked through the acknowledge bit and the byte returned by the next read.

// File: rtl/i2cid_pkg.sv
package i2cid_pkg;
  localparam int ID_LAST = 16;
  localparam int PTR_W   = $clog2(ID_LAST + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_OFS,
    ST_XTRA,
    ST_OACK,
    ST_TX,
    ST_MACK,
    ST_ACKD
  } resp_state_e;
endpackage

// File: rtl/i2cid_line_cond.sv
module i2cid_line_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   dout_d;

  // level changes only when the whole history agrees
  always_comb begin
    dout_d = dout;
    if (&hist_q)       dout_d = 1'b1;
    else if (~|hist_q) dout_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      dout   <= dout_d;
    end
  end
endmodule

// File: rtl/i2cid_bus_events.sv
module i2cid_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  always_comb begin
    scl_rise  = scl_f & ~scl_p;
    scl_fall  = ~scl_f & scl_p;
    start_evt = scl_f & scl_p & sda_p & ~sda_f;
    stop_evt  = scl_f & scl_p & ~sda_p & sda_f;
  end
endmodule

// File: rtl/i2cid_rom.sv
module i2cid_rom
  import i2cid_pkg::*;
(
  input  logic [PTR_W-1:0] idx,
  output logic [7:0]       data
);
  always_comb begin
    case (idx)
      5'h00: data = 8'h44;
      5'h01: data = 8'h50;
      5'h02: data = 8'h2D;
      5'h03: data = 8'h48;
      5'h04: data = 8'h44;
      5'h05: data = 8'h4D;
      5'h06: data = 8'h49;
      5'h07: data = 8'h20;
      5'h08: data = 8'h41;
      5'h09: data = 8'h44;
      5'h0A: data = 8'h41;
      5'h0B: data = 8'h50;
      5'h0C: data = 8'h54;
      5'h0D: data = 8'h4F;
      5'h0E: data = 8'h52;
      5'h0F: data = 8'h04;
      default: data = 8'hFF;
    endcase
  end
endmodule

// File: rtl/i2c_id_responder.sv
module i2c_id_responder
  import i2cid_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h40,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  input  logic slave_en,
  input  logic pwr_up
);
  localparam logic [7:0]       LAST_B = 8'(ID_LAST);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(ID_LAST);

  logic rst_meta, rst_s;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_evt, stop_evt;
  logic active;

  resp_state_e      state_q, state_d;
  logic [3:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             rw_q, rw_d;
  logic             oe_q, oe_d;
  logic [7:0]       rom_byte;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  i2cid_line_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_cond (
    .clk(clk), .rst_n(rst_s), .din(scl_i), .dout(scl_f));
  i2cid_line_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_cond (
    .clk(clk), .rst_n(rst_s), .din(sda_i), .dout(sda_f));

  i2cid_bus_events u_events (
    .clk(clk), .rst_n(rst_s), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt));

  i2cid_rom u_rom (.idx(ptr_q), .data(rom_byte));

  assign active = slave_en & pwr_up;
  assign sda_oe = oe_q;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    rw_d    = rw_q;
    oe_d    = oe_q;
    if (!active) begin
      state_d = ST_IDLE;
      bit_d   = '0;
      ptr_d   = '0;
      oe_d    = 1'b0;
    end else if (start_evt) begin
      state_d = ST_ADDR;
      bit_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_evt) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_OFS, ST_XTRA: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_f};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            bit_d = '0;
            if (state_q == ST_ADDR) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                rw_d    = sh_q[0];
                oe_d    = 1'b1;
                state_d = ST_AACK;
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              if (state_q == ST_OFS)
                ptr_d = (sh_q > LAST_B) ? LAST_P : sh_q[PTR_W-1:0];
              oe_d    = 1'b1;
              state_d = ST_OACK;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            bit_d = '0;
            if (rw_q) begin
              sh_d    = rom_byte;
              oe_d    = ~rom_byte[7];
              state_d = ST_TX;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_OFS;
            end
          end
        end
        ST_OACK: begin
          if (scl_fall) begin
            bit_d   = '0;
            oe_d    = 1'b0;
            state_d = ST_XTRA;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_d = bit_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_q == 4'd8) begin
              oe_d    = 1'b0;
              state_d = ST_MACK;
            end else begin
              sh_d = {sh_q[6:0], 1'b0};
              oe_d = ~sh_q[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            if (!sda_f) begin
              ptr_d   = (ptr_q == LAST_P) ? ptr_q : ptr_q + 1'b1;
              state_d = ST_ACKD;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ACKD: begin
          if (scl_fall) begin
            bit_d   = '0;
            sh_d    = rom_byte;
            oe_d    = ~rom_byte[7];
            state_d = ST_TX;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      rw_q    <= rw_d;
      oe_q    <= oe_d;
    end
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_s)
    ptr_q <= LAST_P); // R7
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    (active && ptr_q == LAST_P && state_q != ST_OFS) |=> ptr_q == LAST_P); // R7
  AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_s)
    !slave_en |=> (!sda_oe && ptr_q == '0)); // R9
  AST_PWR_OFF: assert property (@(posedge clk) disable iff (!rst_s)
    !pwr_up |=> (!sda_oe && ptr_q == '0)); // R10
  AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_s)
    (active && start_evt) |=> state_q == ST_ADDR); // R11
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(active) && !$stable(oe_q)) |-> !scl_f); // R12
endmodule

// File: tb/i2c_id_responder_tb.sv
module i2c_id_responder_tb;
  localparam int Q = 20;

  logic clk, rst_n;
  logic m_scl, m_sda_low;
  logic slave_en, pwr_up;
  logic sda_oe;
  logic sda_line;
  int   total, bad, unstable;
  logic done;

  assign sda_line = ~(m_sda_low | sda_oe);

  i2c_id_responder u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .slave_en(slave_en), .pwr_up(pwr_up));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_at(input int i);
    string s;
    s = "DP-HDMI ADAPTOR";
    if (i > 16) i = 16;
    if (i < 15) return s[i];
    if (i == 15) return 8'h04;
    return 8'hFF;
  endfunction

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; qw();
    m_scl = 1'b1;     qw();
    m_sda_low = 1'b1; qw();
    m_scl = 1'b0;     qw();
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; qw();
    m_scl = 1'b1;     qw();
    m_sda_low = 1'b0; qw(); qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = ~b[i]; qw();
      m_scl = 1'b1; qw(); qw();
      m_scl = 1'b0; qw();
    end
    m_sda_low = 1'b0; qw();
    m_scl = 1'b1; qw();
    ack = ~sda_line; qw();
    m_scl = 1'b0; qw();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = 1'b0; qw();
      m_scl = 1'b1; qw();
      b[i] = sda_line; qw();
      if (sda_line !== b[i]) unstable++;
      m_scl = 1'b0; qw();
    end
    m_sda_low = give_ack; qw();
    m_scl = 1'b1; qw(); qw();
    m_scl = 1'b0; qw();
    m_sda_low = 1'b0;
  endtask

  task automatic write_ofs(input logic [7:0] ofs, input string tag);
    logic a;
    bus_start();
    send_byte(8'h80, a); check({tag, " R2 write addr ack"}, {7'd0, a}, 8'd1);
    send_byte(ofs, a);   check({tag, " R3 offset ack"}, {7'd0, a}, 8'd1);
    bus_stop();
  endtask

  task automatic read_seq(input int n, input int first, input string tag);
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'h81, a); check({tag, " R2 read addr ack"}, {7'd0, a}, 8'd1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      check($sformatf("%s R4/R6 byte %0d", tag, k), b, exp_at(first + k));
    end
    qw();
    check({tag, " R5 released after NACK"}, {7'd0, sda_oe}, 8'd0);
    bus_stop();
  endtask

  task automatic t_reset();
    check("R1 sda_oe after reset", {7'd0, sda_oe}, 8'd0);
    check("R1 line high after reset", {7'd0, sda_line}, 8'd1);
  endtask

  task automatic t_direct_read();
    unstable = 0;
    read_seq(20, 0, "R8 direct read R7 saturate");
    check("R12 data stable while SCL high", unstable[7:0], 8'd0);
  endtask

  task automatic t_offset_and_nack();
    write_ofs(8'h05, "R3 ofs5");
    read_seq(3, 5, "R3 from ofs5");
    read_seq(1, 7, "R5 pointer kept after NACK");
  endtask

  task automatic t_repeated_start();
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'h80, a); check("R11 addr ack", {7'd0, a}, 8'd1);
    send_byte(8'h0E, a); check("R11 ofs ack", {7'd0, a}, 8'd1);
    bus_start();
    send_byte(8'h81, a); check("R11 rep start read ack", {7'd0, a}, 8'd1);
    recv_byte(1'b1, b); check("R11 byte0", b, 8'h52);
    recv_byte(1'b0, b); check("R11 byte1", b, 8'h04);
    bus_stop();
  endtask

  task automatic t_clamp();
    write_ofs(8'h30, "R3 clamp");
    read_seq(2, 16, "R3 R7 clamped read");
  endtask

  task automatic t_extra_write();
    logic a;
    bus_start();
    send_byte(8'h80, a); check("R3 extra addr ack", {7'd0, a}, 8'd1);
    send_byte(8'h02, a); check("R3 extra ofs ack", {7'd0, a}, 8'd1);
    send_byte(8'h99, a); check("R3 extra data ack", {7'd0, a}, 8'd1);
    send_byte(8'h55, a); check("R3 extra data2 ack", {7'd0, a}, 8'd1);
    bus_stop();
    read_seq(1, 2, "R3 extra discarded");
  endtask

  task automatic t_wrong_addr();
    logic a;
    bus_start();
    send_byte(8'h82, a); check("R2 wrong addr no ack", {7'd0, a}, 8'd0);
    send_byte(8'h00, a); check("R2 off bus after mismatch", {7'd0, a}, 8'd0);
    bus_stop();
  endtask

  task automatic t_disable();
    logic a;
    write_ofs(8'h0C, "R9 pre");
    slave_en = 1'b0; qw();
    bus_start();
    send_byte(8'h80, a); check("R9 no ack when disabled", {7'd0, a}, 8'd0);
    bus_stop();
    slave_en = 1'b1; qw();
    read_seq(1, 0, "R9 restart at 0");
  endtask

  task automatic t_lowpower();
    logic a;
    logic [7:0] b;
    write_ofs(8'h0C, "R10 pre");
    pwr_up = 1'b0; qw();
    bus_start();
    send_byte(8'h81, a); check("R10 no ack in low power", {7'd0, a}, 8'd0);
    recv_byte(1'b0, b); check("R10 bus released", b, 8'hFF);
    bus_stop();
    pwr_up = 1'b1; qw();
    read_seq(1, 0, "R10 restart at 0");
  endtask

  initial begin
    total = 0; bad = 0; unstable = 0; done = 1'b0;
    rst_n = 1'b0; m_scl = 1'b1; m_sda_low = 1'b0;
    slave_en = 1'b1; pwr_up = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_direct_read();
    t_offset_and_nack();
    t_repeated_start();
    t_clamp();
    t_extra_write();
    t_wrong_addr();
    t_disable();
    t_lowpower();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end
endmodule